// File: doc/BRIEF.md
# Mailbox Register-Access Request Engine

This engine sits on the host side of a shared mailbox channel. It turns one local command into a complete mailbox exchange. A command is a register read or a register write aimed at a remote device. It carries the device address, the first register address, a byte count and up to four bytes of write data. The engine first rejects bad byte counts. It then waits until the remote side has released the channel and copies the request into the channel one byte per cycle. The header goes in last, after which the engine raises the doorbell. Finally it waits for the acknowledge, judges it, and returns a status code and any read data with a one-cycle done pulse.

The engine serves one command at a time. While `busy` is high, new commands are ignored. Acknowledges whose header code means nothing to the engine are still cleared, but they do not end the wait.

Top module: `mbx_regacc_engine`

## Requirements
- R1: While reset is held and right after it, `busy`, `done`, `req_wr_en`, `doorbell` and `ack_clr` are all low.
- R2: A byte count of 0 or above 4 ends the command with status 1 (invalid). `done` rises in the second cycle after the command is taken, and no request byte is written and no doorbell is raised.
- R3: While `chan_busy` is high, no request byte is written. Writing starts only once `chan_busy` is low.
- R4: Request bytes are written one per cycle: address 0 holds the device address, address 1 the register address and address 2 the count. For a write, data byte i (bits 8i+7..8i of `cmd_wdata`) goes to address 4+i, for i below the count. A read writes no data bytes.
- R5: The header is the last byte written, at address 15. Its code is 1 for a write and 2 for a read. `doorbell` pulses for one cycle, in the cycle right after the header write, once per command.
- R6: A read completes with status 0 only if the acknowledge header is 2 and the return code is 0. `rdata` then carries the first count bytes of `ack_rdata` and zero in the bytes above them.
- R7: A write completes with status 0 only if the acknowledge header is 1 and the return code is 0. `rdata` is then zero.
- R8: In every other case, the command completes with status 2 (I/O error) and zero `rdata`. This covers a known header that does not match the command, and any nonzero return code. Status 3 never appears.
- R9: An acknowledge whose header is neither 1 nor 2 gets its `ack_clr` pulse, but the engine keeps waiting for a valid one.
- R10: Each acknowledge the engine takes is answered with an `ack_clr` pulse exactly one cycle long.
- R11: `done` is a one-cycle pulse and `busy` is high from the cycle after a command is taken up to and including the done cycle. A command presented while busy is ignored and, if still held, is taken after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present (taken when idle) |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_dev | input | 8 | Remote device address |
| cmd_reg | input | 8 | First register address |
| cmd_count | input | 8 | Byte count |
| cmd_wdata | input | 32 | Write data, byte 0 in the low bits |
| busy | output | 1 | Engine occupied |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 invalid, 2 I/O error |
| rdata | output | 32 | Read result, valid with done |
| chan_busy | input | 1 | Channel still owned by the remote side |
| req_wr_en | output | 1 | Request byte write strobe |
| req_wr_addr | output | 4 | Request byte address (15 = header) |
| req_wr_data | output | 8 | Request byte value |
| doorbell | output | 1 | Doorbell pulse to the remote side |
| ack_pending | input | 1 | Acknowledge interrupt pending |
| ack_hdr | input | 8 | Acknowledge header code |
| ack_code | input | 8 | Acknowledge return code |
| ack_rdata | input | 32 | Acknowledge read data |
| ack_clr | output | 1 | Clears the pending acknowledge |

## Verification
Two things can land in the same cycle. The first is the done pulse together with the `ack_clr` of the acknowledge that caused it. The second is that done pulse together with a new command that is already waiting at the inputs. The bench keeps `cmd_valid` high with a second command through the whole first transaction. It then checks three things: the first request still carries the first command's fields, exactly one clear was issued, and the second command is taken only in the cycle after done. In a separate case, a junk acknowledge comes ahead of the real one, so a clear and a completion appear in separate cycles, and the bench checks that two clears are counted.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam logic [7:0] HDR_WRITE = 8'd1;
    localparam logic [7:0] HDR_READ  = 8'd2;

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_INVAL = 2'd1,
        ST_IOERR = 2'd2
    } status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_WAIT_IDLE,
        S_WRITE_FIELDS,
        S_RING,
        S_WAIT_ACK,
        S_DONE
    } state_e;

endpackage

// File: rtl/mbx_field_seq.sv
module mbx_field_seq #(
    parameter int MAX_BYTES = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_OFS  = 4,
    parameter int IDX_W     = 3
) (
    input  logic [IDX_W-1:0]       idx,
    input  logic                   is_rd,
    input  logic [7:0]             dev,
    input  logic [7:0]             regad,
    input  logic [7:0]             cnt,
    input  logic [8*MAX_BYTES-1:0] wdata,
    output logic [ADDR_W-1:0]      addr,
    output logic [7:0]             data,
    output logic                   last
);
    import mbx_pkg::*;

    localparam logic [IDX_W-1:0] N_FIXED = IDX_W'(3);

    logic [7:0]       wbyte [MAX_BYTES];
    logic [IDX_W-1:0] n_data;
    logic [IDX_W-1:0] hdr_idx;
    logic [IDX_W-1:0] dsel;

    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_bytes
        assign wbyte[g] = wdata[8*g +: 8];
    end

    assign n_data  = is_rd ? '0 : IDX_W'(cnt);
    assign hdr_idx = N_FIXED + n_data;
    assign dsel    = idx - N_FIXED;
    assign last    = (idx == hdr_idx);

    always_comb begin
        addr = '1;
        data = is_rd ? HDR_READ : HDR_WRITE;
        if (idx < N_FIXED) begin
            addr = ADDR_W'(idx);
            case (idx[1:0])
                2'd0:    data = dev;
                2'd1:    data = regad;
                default: data = cnt;
            endcase
        end else if (idx < hdr_idx) begin
            addr = ADDR_W'(DATA_OFS) + ADDR_W'(dsel);
            data = '0;
            for (int k = 0; k < MAX_BYTES; k++) begin
                if (dsel == IDX_W'(k)) data = wbyte[k];
            end
        end
    end

endmodule

// File: rtl/mbx_ack_eval.sv
module mbx_ack_eval #(
    parameter int MAX_BYTES = 4
) (
    input  logic                   exp_rd,
    input  logic [7:0]             cnt,
    input  logic [7:0]             hdr,
    input  logic [7:0]             code,
    input  logic [8*MAX_BYTES-1:0] ack_data,
    output logic                   known,
    output logic                   ok,
    output logic [8*MAX_BYTES-1:0] rdata
);
    import mbx_pkg::*;

    logic [7:0] exp_hdr;

    assign exp_hdr = exp_rd ? HDR_READ : HDR_WRITE;
    assign known   = (hdr == HDR_READ) || (hdr == HDR_WRITE);
    assign ok      = (hdr == exp_hdr) && (code == 8'd0);

    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_mask
        assign rdata[8*g +: 8] = (ok && exp_rd && (cnt > 8'(g))) ? ack_data[8*g +: 8] : 8'd0;
    end

endmodule

// File: rtl/mbx_regacc_engine.sv
module mbx_regacc_engine #(
    parameter int MAX_BYTES = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_OFS  = 4,
    localparam int WD_W     = 8 * MAX_BYTES,
    localparam int IDX_W    = $clog2(MAX_BYTES + 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_read,
    input  logic [7:0]        cmd_dev,
    input  logic [7:0]        cmd_reg,
    input  logic [7:0]        cmd_count,
    input  logic [WD_W-1:0]   cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic [WD_W-1:0]   rdata,
    input  logic              chan_busy,
    output logic              req_wr_en,
    output logic [ADDR_W-1:0] req_wr_addr,
    output logic [7:0]        req_wr_data,
    output logic              doorbell,
    input  logic              ack_pending,
    input  logic [7:0]        ack_hdr,
    input  logic [7:0]        ack_code,
    input  logic [WD_W-1:0]   ack_rdata,
    output logic              ack_clr
);
    import mbx_pkg::*;

    typedef struct packed {
        state_e            state;
        logic              is_rd;
        logic [7:0]        dev;
        logic [7:0]        regad;
        logic [7:0]        cnt;
        logic [WD_W-1:0]   wdata;
        logic [IDX_W-1:0]  idx;
        status_e           status;
        logic [WD_W-1:0]   rdata;
        logic              clr;
    } regs_t;

    regs_t q, d;

    logic            fld_last;
    logic            ack_known;
    logic            ack_ok;
    logic [WD_W-1:0] ack_masked;

    mbx_field_seq #(
        .MAX_BYTES(MAX_BYTES),
        .ADDR_W   (ADDR_W),
        .DATA_OFS (DATA_OFS),
        .IDX_W    (IDX_W)
    ) seq_i (
        .idx  (q.idx),
        .is_rd(q.is_rd),
        .dev  (q.dev),
        .regad(q.regad),
        .cnt  (q.cnt),
        .wdata(q.wdata),
        .addr (req_wr_addr),
        .data (req_wr_data),
        .last (fld_last)
    );

    mbx_ack_eval #(
        .MAX_BYTES(MAX_BYTES)
    ) eval_i (
        .exp_rd  (q.is_rd),
        .cnt     (q.cnt),
        .hdr     (ack_hdr),
        .code    (ack_code),
        .ack_data(ack_rdata),
        .known   (ack_known),
        .ok      (ack_ok),
        .rdata   (ack_masked)
    );

    always_comb begin
        d     = q;
        d.clr = 1'b0;
        unique case (q.state)
            S_IDLE: begin
                if (cmd_valid) begin
                    d.is_rd = cmd_read;
                    d.dev   = cmd_dev;
                    d.regad = cmd_reg;
                    d.cnt   = cmd_count;
                    d.wdata = cmd_wdata;
                    d.state = S_CHECK;
                end
            end
            S_CHECK: begin
                if ((q.cnt == 8'd0) || (q.cnt > 8'(MAX_BYTES))) begin
                    d.status = ST_INVAL;
                    d.rdata  = '0;
                    d.state  = S_DONE;
                end else begin
                    d.state = S_WAIT_IDLE;
                end
            end
            S_WAIT_IDLE: begin
                if (!chan_busy) begin
                    d.idx   = '0;
                    d.state = S_WRITE_FIELDS;
                end
            end
            S_WRITE_FIELDS: begin
                if (fld_last) d.state = S_RING;
                else          d.idx   = q.idx + IDX_W'(1);
            end
            S_RING: begin
                d.state = S_WAIT_ACK;
            end
            S_WAIT_ACK: begin
                if (ack_pending && !q.clr) begin
                    d.clr = 1'b1;
                    if (ack_known) begin
                        d.status = ack_ok ? ST_OK : ST_IOERR;
                        d.rdata  = ack_masked;
                        d.state  = S_DONE;
                    end
                end
            end
            S_DONE: begin
                d.state = S_IDLE;
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = (q.state != S_IDLE);
    assign done      = (q.state == S_DONE);
    assign status    = q.status;
    assign rdata     = q.rdata;
    assign req_wr_en = (q.state == S_WRITE_FIELDS);
    assign doorbell  = (q.state == S_RING);
    assign ack_clr   = q.clr;

endmodule

// File: rtl/mbx_regacc_chk.sv
module mbx_regacc_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [1:0]        status,
    input logic              req_wr_en,
    input logic [ADDR_W-1:0] req_wr_addr,
    input logic [7:0]        req_wr_data,
    input logic              doorbell,
    input logic              ack_clr
);
    // R5
    hdr_before_bell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        doorbell |-> $past(req_wr_en && (req_wr_addr == '1)));
    // R5
    hdr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr_en && (req_wr_addr == '1)) |-> ((req_wr_data == 8'd1) || (req_wr_data == 8'd2)));
    // R2
    inval_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (status == 2'd1)) |-> (!$past(req_wr_en) && !$past(doorbell) && !$past(req_wr_en, 2)));
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    // R10
    clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_clr |=> !ack_clr);
    // R4
    wr_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_wr_en |-> busy);
    // R8
    status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status != 2'd3));
endmodule

bind mbx_regacc_engine mbx_regacc_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .status     (status),
    .req_wr_en  (req_wr_en),
    .req_wr_addr(req_wr_addr),
    .req_wr_data(req_wr_data),
    .doorbell   (doorbell),
    .ack_clr    (ack_clr)
);

// File: tb/mbx_regacc_engine_tb_top.sv
`timescale 1ns/1ps
module mbx_regacc_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_read = 1'b0;
    logic [7:0]  cmd_dev = '0;
    logic [7:0]  cmd_reg = '0;
    logic [7:0]  cmd_count = '0;
    logic [31:0] cmd_wdata = '0;
    logic        busy, done;
    logic [1:0]  status;
    logic [31:0] rdata;
    logic        chan_busy = 1'b0;
    logic        req_wr_en;
    logic [3:0]  req_wr_addr;
    logic [7:0]  req_wr_data;
    logic        doorbell;
    logic        ack_pending;
    logic [7:0]  ack_hdr;
    logic [7:0]  ack_code;
    logic [31:0] ack_rdata;
    logic        ack_clr;

    always #10 clk = ~clk;

    mbx_regacc_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
        .cmd_dev(cmd_dev), .cmd_reg(cmd_reg), .cmd_count(cmd_count), .cmd_wdata(cmd_wdata),
        .busy(busy), .done(done), .status(status), .rdata(rdata), .chan_busy(chan_busy),
        .req_wr_en(req_wr_en), .req_wr_addr(req_wr_addr), .req_wr_data(req_wr_data),
        .doorbell(doorbell), .ack_pending(ack_pending), .ack_hdr(ack_hdr),
        .ack_code(ack_code), .ack_rdata(ack_rdata), .ack_clr(ack_clr)
    );

    // Remote-side settings for the current command
    logic        cur_junk = 1'b0;
    logic [7:0]  cur_hdr = '0;
    logic [7:0]  cur_rc = '0;
    logic [31:0] cur_ad = '0;
    logic        clr_mem = 1'b0;

    // Monitor of the request area
    logic [7:0]  mem [16];
    int          wr_cnt = 0, bell_cnt = 0, clr_cnt = 0;
    logic [3:0]  last_addr = '0;
    logic        prev_hdr = 1'b0, bell_after_hdr = 1'b0;

    always @(posedge clk) begin
        if (clr_mem) begin
            for (int i = 0; i < 16; i++) mem[i] <= 8'h00;
        end else if (req_wr_en) begin
            mem[req_wr_addr] <= req_wr_data;
        end
        if (req_wr_en) begin
            wr_cnt    <= wr_cnt + 1;
            last_addr <= req_wr_addr;
        end
        prev_hdr <= req_wr_en && (req_wr_addr == 4'hF);
        if (doorbell) begin
            bell_cnt       <= bell_cnt + 1;
            bell_after_hdr <= prev_hdr;
        end
        if (ack_clr) clr_cnt <= clr_cnt + 1;
    end

    // Remote responder
    int         delay = 0;
    logic [1:0] stage = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            ack_pending <= 1'b0;
            delay       <= 0;
            stage       <= '0;
        end else begin
            if (doorbell) begin
                delay <= 3;
                stage <= cur_junk ? 2'd1 : 2'd2;
            end else if (delay != 0) begin
                delay <= delay - 1;
                if (delay == 1) ack_pending <= 1'b1;
            end
            if (ack_clr) begin
                ack_pending <= 1'b0;
                if (stage == 2'd1) begin
                    stage <= 2'd2;
                    delay <= 3;
                end
            end
        end
    end
    assign ack_hdr   = (stage == 2'd1) ? 8'h7E : cur_hdr;
    assign ack_code  = cur_rc;
    assign ack_rdata = cur_ad;

    int n_chk = 0, n_fail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic        rd;
        logic [7:0]  cnt;
        logic [31:0] wd;
        logic        junk;
        logic [7:0]  hdr;
        logic [7:0]  rc;
        logic [31:0] ad;
        logic [1:0]  est;
        logic [31:0] erd;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd4,   32'hA1B2C3D4, 1'b0, 8'd1, 8'd0, 32'h0,        2'd0, 32'h0},
        '{1'b0, 8'd1,   32'h000000EE, 1'b0, 8'd1, 8'd0, 32'h0,        2'd0, 32'h0},
        '{1'b1, 8'd4,   32'h0,        1'b0, 8'd2, 8'd0, 32'h11223344, 2'd0, 32'h11223344},
        '{1'b1, 8'd2,   32'h0,        1'b0, 8'd2, 8'd0, 32'h55667788, 2'd0, 32'h00007788},
        '{1'b1, 8'd1,   32'h0,        1'b0, 8'd2, 8'd0, 32'hCAFEBABE, 2'd0, 32'h000000BE},
        '{1'b1, 8'd3,   32'h0,        1'b0, 8'd2, 8'd5, 32'h99999999, 2'd2, 32'h0},
        '{1'b0, 8'd2,   32'h00003344, 1'b0, 8'd2, 8'd0, 32'h0,        2'd2, 32'h0},
        '{1'b1, 8'd4,   32'h0,        1'b0, 8'd1, 8'd0, 32'h12345678, 2'd2, 32'h0},
        '{1'b0, 8'd0,   32'h0,        1'b0, 8'd1, 8'd0, 32'h0,        2'd1, 32'h0},
        '{1'b1, 8'd5,   32'h0,        1'b0, 8'd2, 8'd0, 32'h0,        2'd1, 32'h0},
        '{1'b1, 8'd255, 32'h0,        1'b0, 8'd2, 8'd0, 32'h0,        2'd1, 32'h0},
        '{1'b0, 8'd3,   32'h00665544, 1'b1, 8'd1, 8'd0, 32'h0,        2'd0, 32'h0},
        '{1'b1, 8'd4,   32'h0,        1'b1, 8'd2, 8'd0, 32'h0A0B0C0D, 2'd0, 32'h0A0B0C0D}
    };

    task automatic wipe();
        clr_mem = 1'b1;
        @(negedge clk);
        clr_mem = 1'b0;
    endtask

    // Presents one command for a cycle and waits for done; returns cycles waited
    task automatic run_cmd(input logic rd, input logic [7:0] dev, input logic [7:0] rg,
                           input logic [7:0] cnt, input logic [31:0] wd, output int n);
        cmd_read = rd; cmd_dev = dev; cmd_reg = rg; cmd_count = cnt; cmd_wdata = wd;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 1;
        while (!done && n < 300) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n, w0, b0, c0, nexp;
        string rq;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 wr_en", 32'(req_wr_en), 0);
        chk("R1 doorbell", 32'(doorbell), 0);
        chk("R1 ack_clr", 32'(ack_clr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", 32'(busy), 0);

        for (int v = 0; v < NV; v++) begin
            cur_junk = VECS[v].junk; cur_hdr = VECS[v].hdr;
            cur_rc = VECS[v].rc; cur_ad = VECS[v].ad;
            wipe();
            w0 = wr_cnt; b0 = bell_cnt; c0 = clr_cnt;
            run_cmd(VECS[v].rd, 8'h40 + 8'(v), 8'h10 + 8'(v), VECS[v].cnt, VECS[v].wd, n);
            rq = (VECS[v].est == 2'd1) ? "R2" : (VECS[v].est == 2'd2) ? "R8" :
                 VECS[v].rd ? "R6" : "R7";
            chk({rq, " done seen"}, 32'(done), 1);
            chk({rq, " status"}, 32'(status), 32'(VECS[v].est));
            chk({rq, " rdata"}, rdata, VECS[v].erd);
            @(negedge clk);
            if (VECS[v].est == 2'd1) begin
                chk("R2 done latency", 32'(n), 2);
                chk("R2 no writes", 32'(wr_cnt - w0), 0);
                chk("R2 no doorbell", 32'(bell_cnt - b0), 0);
            end else begin
                nexp = 4 + (VECS[v].rd ? 0 : int'(VECS[v].cnt));
                chk("R4 write count", 32'(wr_cnt - w0), 32'(nexp));
                chk("R4 dev byte", 32'(mem[0]), 32'(8'h40 + 8'(v)));
                chk("R4 reg byte", 32'(mem[1]), 32'(8'h10 + 8'(v)));
                chk("R4 count byte", 32'(mem[2]), 32'(VECS[v].cnt));
                for (int i = 0; i < 4; i++) begin
                    if (!VECS[v].rd && i < int'(VECS[v].cnt))
                        chk("R4 data byte", 32'(mem[4+i]), 32'(VECS[v].wd[8*i +: 8]));
                    else
                        chk("R4 unused data byte", 32'(mem[4+i]), 0);
                end
                chk("R5 header code", 32'(mem[15]), VECS[v].rd ? 2 : 1);
                chk("R5 header last", 32'(last_addr), 15);
                chk("R5 one doorbell", 32'(bell_cnt - b0), 1);
                chk("R5 doorbell after header", 32'(bell_after_hdr), 1);
                if (VECS[v].junk) chk("R9 junk cleared and waited", 32'(clr_cnt - c0), 2);
                else              chk("R10 one clear", 32'(clr_cnt - c0), 1);
            end
        end

        // R3: channel held busy
        cur_junk = 1'b0; cur_hdr = 8'd1; cur_rc = 8'd0;
        wipe();
        chan_busy = 1'b1;
        w0 = wr_cnt;
        cmd_read = 1'b0; cmd_dev = 8'h77; cmd_reg = 8'h01; cmd_count = 8'd2; cmd_wdata = 32'h0000BEEF;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (12) @(negedge clk);
        chk("R3 no write while channel busy", 32'(wr_cnt - w0), 0);
        chk("R3 engine busy while waiting", 32'(busy), 1);
        chan_busy = 1'b0;
        n = 0;
        while (!done && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk("R3 status after release", 32'(status), 0);
        @(negedge clk);
        chk("R3 writes after release", 32'(wr_cnt - w0), 6);

        // R11: second command held across the first one's done
        wipe();
        w0 = wr_cnt; c0 = clr_cnt;
        cmd_read = 1'b0; cmd_dev = 8'h11; cmd_reg = 8'h02; cmd_count = 8'd1; cmd_wdata = 32'h000000A5;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_dev = 8'h22; cmd_wdata = 32'h0000005A;
        n = 0;
        while (!done && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk("R11 first status", 32'(status), 0);
        chk("R11 first dev kept", 32'(mem[0]), 32'h11);
        chk("R11 first data kept", 32'(mem[4]), 32'hA5);
        @(negedge clk);
        chk("R11 idle after done", 32'(busy), 0);
        chk("R11 done one cycle", 32'(done), 0);
        chk("R10 single clear", 32'(clr_cnt - c0), 1);
        chk("R11 first writes", 32'(wr_cnt - w0), 5);
        clr_mem = 1'b1;
        @(negedge clk);
        clr_mem = 1'b0;
        chk("R11 second taken", 32'(busy), 1);
        cmd_valid = 1'b0;
        n = 0;
        while (!done && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk("R11 second status", 32'(status), 0);
        chk("R11 second dev", 32'(mem[0]), 32'h22);
        chk("R11 second data", 32'(mem[4]), 32'h5A);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule